// File: doc/BRIEF.md
# Third-Order Cascaded Fractional Ratio Modulator

This block produces a new integer division ratio on every cycle of a fractional-N divider's output clock, so that the average ratio equals a base integer plus a binary fraction. It is built from three first-order phase accumulators in cascade. The first accumulator integrates the fraction word. Each later accumulator integrates the residue that the stage before it leaves. The three carry bits are then differenced and summed into a small signed offset. This shapes the quantisation error towards high frequencies, where the loop filter removes it.

The offset is added to a base ratio in the range 64 to 127. The result is limited to that range and handed to a multi-modulus divider as a 6-bit control word holding the ratio minus 64. A flag shows any cycle in which the limit changed the value. The raw offset is also brought out, for observation and for downstream checks.

Top module: `mash111_ratio_gen`

## Requirements
- R1: While reset is low, `ratio_ctrl` is 0, `offset` is 0 and `clamped` is 0.
- R2: After every update, `offset`, read as a 4-bit two's complement value, lies between -3 and +4 inclusive.
- R3: With `frac_word` held at 0 from reset, `offset` stays 0 on every update.
- R4: Let S(n) be the sum of `offset` over the first n updates after reset, with a constant fraction F. Then S(n) - floor(n·F/2^15) lies between -1 and +2 for every n.
- R5: After each update, `ratio_ctrl` equals min(max(base + offset, 64), 127) - 64. Here base is the `base_ratio` value captured at that update, and offset is the value shown in the same cycle.
- R6: `clamped` is 1 exactly when base + offset falls outside 64..127. It goes high both below the range (base 64 with negative offsets) and above it (base 127 with positive offsets).
- R7: After 2^15 updates with constant F, the offset sum lies in F-1..F+2. For F = 2^15-1 this gives an average ratio of base plus almost one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided output clock; one ratio update per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_ratio | input | 7 | Integer part of the ratio, nominally 64..127 |
| frac_word | input | 15 | Fraction in units of 2^-15 |
| ratio_ctrl | output | 6 | Limited ratio minus 64, for the divider |
| offset | output | 4 | Signed dither offset before limiting |
| clamped | output | 1 | High when the limit altered the ratio |

## Verification
The bench builds the block with its default widths: a 15-bit accumulator and a 6-bit control word. Those widths make a full fractional period of 32768 updates short enough to run several times. Each of four fractions is therefore followed through its whole period, including the extremes 1 and 2^15-1. The running offset sum is compared against the exact integer quotient on every update. The 7-bit base range lets base values of 64 and 127 drive the limiter against both of its edges.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int OFFS_W = 4;
  typedef logic signed [OFFS_W-1:0] offs_t;

  // offset = c1 + (1 - z^-1) c2 + (1 - z^-1)^2 c3
  function automatic int combine_carries(
      input logic c1, input logic c2, input logic c2_d,
      input logic c3, input logic c3_d, input logic c3_dd);
    int v;
    v = int'(c1) + int'(c2) - int'(c2_d) + int'(c3) - 2 * int'(c3_d) + int'(c3_dd);
    return v;
  endfunction

  function automatic int limit_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/mash_acc.sv
module mash_acc #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] add_in,
  output logic [W-1:0] residue,
  output logic         carry
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  always_comb sum = {1'b0, acc_q} + {1'b0, add_in};
  assign residue = sum[W-1:0];
  assign carry   = sum[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= residue;
  end

  // R4: a carry is emitted exactly when the stored phase wrapped past 2^W
  p_carry_wraps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    carry == (residue < add_in));
endmodule

// File: rtl/mash_combiner.sv
module mash_combiner
  import mash_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  c1,
  input  logic  c2,
  input  logic  c3,
  output offs_t offset_q
);
  logic c2_d, c3_d, c3_dd;
  int   raw;

  always_comb raw = combine_carries(c1, c2, c2_d, c3, c3_d, c3_dd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_d     <= 1'b0;
      c3_d     <= 1'b0;
      c3_dd    <= 1'b0;
      offset_q <= '0;
    end else begin
      c2_d     <= c2;
      c3_d     <= c3;
      c3_dd    <= c3_d;
      offset_q <= offs_t'(raw);
    end
  end

  p_offset_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_q >= -4'sd3) && (offset_q <= 4'sd4));
endmodule

// File: rtl/ratio_limit.sv
module ratio_limit
  import mash_pkg::*;
#(
  parameter int CTRL_W = 6,
  localparam int BASE_W = CTRL_W + 1,
  localparam int LO = 2 ** CTRL_W,
  localparam int HI = 2 ** (CTRL_W + 1) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] base_q,
  input  offs_t             offset_q,
  output logic [CTRL_W-1:0] ratio_ctrl,
  output logic              clamped
);
  int total, lim;

  always_comb begin
    total      = int'(base_q) + int'(offset_q);
    lim        = limit_int(total, LO, HI);
    ratio_ctrl = CTRL_W'(lim - LO);
    clamped    = (total != lim);
  end

  // R6: a limited ratio sits on one of the two range edges
  p_clamp_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clamped |-> (ratio_ctrl == '0 || ratio_ctrl == '1));
endmodule

// File: rtl/mash111_ratio_gen.sv
module mash111_ratio_gen
  import mash_pkg::*;
#(
  parameter int ACC_W  = 15,
  parameter int CTRL_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CTRL_W:0]     base_ratio,
  input  logic [ACC_W-1:0]    frac_word,
  output logic [CTRL_W-1:0]   ratio_ctrl,
  output logic signed [3:0]   offset,
  output logic                clamped
);
  localparam int STAGES = 3;
  localparam int BASE_W = CTRL_W + 1;
  localparam int LO     = 2 ** CTRL_W;

  logic [ACC_W-1:0] stage_in  [STAGES];
  logic [ACC_W-1:0] stage_res [STAGES];
  logic [STAGES-1:0] stage_c;
  logic [BASE_W-1:0] base_q;
  offs_t offset_q;

  assign stage_in[0] = frac_word;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s > 0) begin : g_link
      assign stage_in[s] = stage_res[s-1];
    end
    mash_acc #(.W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_in  (stage_in[s]),
      .residue (stage_res[s]),
      .carry   (stage_c[s])
    );
  end

  mash_combiner u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .c1       (stage_c[0]),
    .c2       (stage_c[1]),
    .c3       (stage_c[2]),
    .offset_q (offset_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= BASE_W'(LO);
    else        base_q <= base_ratio;
  end

  ratio_limit #(.CTRL_W(CTRL_W)) u_lim (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_q     (base_q),
    .offset_q   (offset_q),
    .ratio_ctrl (ratio_ctrl),
    .clamped    (clamped)
  );

  assign offset = offset_q;

  // R5: with the base steady, the control word cannot move more than the offset span
  p_ctrl_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q == $past(base_q)) |->
      ((int'(ratio_ctrl) - int'($past(ratio_ctrl)) <= 7) &&
       (int'(ratio_ctrl) - int'($past(ratio_ctrl)) >= -7)));
endmodule

// File: tb/mash111_ratio_gen_bench.sv
module mash111_ratio_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] base_ratio = 7'd64;
  logic [14:0] frac_word = '0;
  logic [5:0] ratio_ctrl;
  logic signed [3:0] offset;
  logic clamped;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mash111_ratio_gen u_mash111_ratio_gen (
    .clk(clk), .rst_n(rst_n), .base_ratio(base_ratio), .frac_word(frac_word),
    .ratio_ctrl(ratio_ctrl), .offset(offset), .clamped(clamped)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int b, input int f, input int n, output int sat_seen);
    longint sum;
    longint fl;
    int d, tot, lim;
    sat_seen = 0;
    sum = 0;
    @(negedge clk);
    rst_n = 1'b0;
    base_ratio = 7'(b);
    frac_word = 15'(f);
    @(negedge clk);
    chk(ratio_ctrl == 6'd0, "R1 ratio_ctrl", ratio_ctrl, 0);
    chk(offset == 4'sd0, "R1 offset", offset, 0);
    chk(clamped == 1'b0, "R1 clamped", clamped, 0);
    rst_n = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      d = int'(offset);
      sum += d;
      chk(d >= -3 && d <= 4, "R2 offset range", d, 0);
      if (f == 0) chk(d == 0, "R3 zero fraction", d, 0);
      tot = b + d;
      lim = (tot < 64) ? 64 : (tot > 127) ? 127 : tot;
      chk(int'(ratio_ctrl) == lim - 64, "R5 ratio_ctrl", ratio_ctrl, lim - 64);
      chk(clamped == (tot != lim), "R6 clamped", clamped, (tot != lim));
      if (clamped) sat_seen++;
      fl = (longint'(k) * longint'(f)) >>> 15;
      chk(sum - fl >= -1 && sum - fl <= 2, "R4 running sum error", sum, fl);
    end
    if (n == 32768)
      chk(sum >= f - 1 && sum <= f + 2, "R7 full-period sum", sum, f);
  endtask

  initial begin
    int s;
    repeat (2) @(negedge clk);
    run(90, 0, 300, s);
    chk(s == 0, "R6 no clamp at zero fraction", s, 0);
    run(90, 1, 32768, s);
    run(100, 12345, 32768, s);
    chk(s == 0, "R6 no clamp mid range", s, 0);
    run(80, 16384, 32768, s);
    run(90, 32767, 32768, s);
    run(64, 20000, 3000, s);
    chk(s > 0, "R6 low clamp reached", s, 1);
    run(127, 20000, 3000, s);
    chk(s > 0, "R6 high clamp reached", s, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule